// File: doc/BRIEF.md
# Rectangular-Window DMA Address Generator

This block drives the address side of a memory-to-memory copy channel that lifts a rectangular window out of a larger frame buffer, or places one into it. Software programs a start address for each side, a transfer width code, a beat count, a row length shared by both sides, a per-side gap value and a per-side skip enable, then pulses `start`. The block checks the settings. If they are acceptable, it issues one read and one write per clock through a single-cycle memory port until the programmed number of beats is done.

Both addresses only ever increase. Within a row each address steps by one transfer unit, which is `1 << width_code` bytes. When a side has skip enabled, the beat that closes a row is followed by a jump of `hole` units instead. Programming `hole` as the gap between rows in units plus one lands the address on the first unit of the next row. The read data is realigned from the source byte lane to the destination byte lane, and the write strobes cover exactly one unit. A one-cycle `done` pulse marks the end of a transfer. A bad configuration produces a one-cycle `err` pulse and no transfer.

Top module: `pip_addr_gen`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, `busy`, `done`, `err`, `mem_rd_en` and `mem_wr_en` are low.
- R2: An accepted `start` is followed in the next cycle by the first beat, with `mem_rd_addr` equal to `src_start` and `mem_wr_addr` equal to `dst_start`. Exactly `beat_total` beats follow on consecutive cycles. In each of them `mem_rd_en`, `mem_wr_en` and `busy` are all high.
- R3: A side whose skip enable is low advances by exactly `1 << width_code` bytes after every beat, whatever its `hole` value and `boundary` are.
- R4: A side whose skip enable is high advances by `hole << width_code` bytes after every beat that ends a row, and by one unit after every other beat. Rows are `boundary` beats long and are counted from the first beat, so a row length of 1 jumps after every beat and a final partial row is allowed.
- R5: The source and destination sides keep their own hole value and skip enable, but both use the same `boundary`.
- R6: Width codes 0, 1 and 2 select 1-, 2- and 4-byte units. The unit read at byte lane `mem_rd_addr mod 4` of `mem_rd_data` appears at byte lane `mem_wr_addr mod 4` of `mem_wr_data`. `mem_wr_strb` has exactly those unit bytes set, with bit i standing for byte lane i.
- R7: In the cycle after the last beat, `done` is high for one cycle while `busy` is still high and the memory enables are low. In the next cycle `busy` is low.
- R8: In any of the following cases `start` is rejected: `beat_total` is 0 or above 65535, `width_code` is 3, a start address is not a multiple of the unit size, or `boundary` is 0 while either skip enable is set. A rejected `start` gives an `err` pulse one cycle long in the next cycle, no beat, and `busy` stays low. A `boundary` of 0 with both skips off is accepted.
- R9: A `start`, together with any change to the settings while a transfer is running, has no effect on the addresses or the beat count of that transfer.
- R10: A `beat_total` of exactly 65535 is accepted and runs the full number of beats. A `beat_total` of 65536 is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a transfer with the current settings |
| src_start | input | 32 | Source byte start address |
| dst_start | input | 32 | Destination byte start address |
| width_code | input | 2 | Unit size code: 0 byte, 1 halfword, 2 word |
| beat_total | input | 17 | Number of beats (units) to copy |
| boundary | input | 16 | Row length in units, shared by both sides |
| src_hole | input | 16 | Source advance in units after a row ends |
| dst_hole | input | 16 | Destination advance in units after a row ends |
| src_skip | input | 1 | Enables row jumps on the source side |
| dst_skip | input | 1 | Enables row jumps on the destination side |
| busy | output | 1 | Transfer in progress, including the done cycle |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle pulse for a rejected start |
| mem_rd_en | output | 1 | Read strobe for this cycle's beat |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_data | input | 32 | Read data returned in the same cycle |
| mem_wr_en | output | 1 | Write strobe for this cycle's beat |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 32 | Write data, realigned to the destination lane |
| mem_wr_strb | output | 4 | Byte-lane write enables |

## Verification
The transfers tried are the following:
- Skip off on both sides with a large hole programmed, which shows that the hole is ignored.
- Skip on for both sides with different holes, and skip on for one side only, which together separate the shared row count from the per-side jump values.
- A row length of one, and a beat count that stops mid-row.
- Byte and halfword units whose source and destination lanes differ, which exposes any lane or strobe mix-up.
- A restart with different settings issued while a transfer is running.
- Each rejection cause on its own, plus row length zero with skips off, which must be accepted.
- The count limit on both sides of 65535.

// File: rtl/pip_pkg.sv
package pip_pkg;

   typedef enum logic [1:0] {
      PIP_IDLE = 2'd0,
      PIP_RUN  = 2'd1,
      PIP_DONE = 2'd2
   } pip_state_e;

   localparam int unsigned PIP_SIDES    = 2;
   localparam int unsigned PIP_SIDE_SRC = 0;
   localparam int unsigned PIP_SIDE_DST = 1;

   function automatic logic [2:0] pip_align_mask(input logic [1:0] w);
      logic [2:0] m;
      case (w)
         2'd0:    m = 3'b000;
         2'd1:    m = 3'b001;
         2'd2:    m = 3'b011;
         default: m = 3'b111;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/pip_cfg_check.sv
module pip_cfg_check
   import pip_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CNT_IN_W   = 17,
   parameter int unsigned BND_W      = 16,
   parameter int unsigned MAX_BEATS  = 65535,
   parameter int unsigned MAX_W_CODE = 2
) (
   input  logic [1:0]          width_code,
   input  logic [ADDR_W-1:0]   src_start,
   input  logic [ADDR_W-1:0]   dst_start,
   input  logic [CNT_IN_W-1:0] beat_total,
   input  logic [BND_W-1:0]    boundary,
   input  logic                src_skip,
   input  logic                dst_skip,
   output logic                cfg_ok
);

   localparam logic [CNT_IN_W-1:0] MAX_CNT  = CNT_IN_W'(MAX_BEATS);
   localparam logic [1:0]          MAX_CODE = 2'(MAX_W_CODE);

   logic       width_bad;
   logic       count_bad;
   logic       align_bad;
   logic       bound_bad;
   logic [2:0] amask;

   always_comb begin
      amask     = pip_align_mask(width_code);
      width_bad = (width_code > MAX_CODE);
      count_bad = (beat_total == '0) || (beat_total > MAX_CNT);
      align_bad = ((src_start[2:0] & amask) != 3'b000) ||
                  ((dst_start[2:0] & amask) != 3'b000);
      bound_bad = (boundary == '0) && (src_skip || dst_skip);
      cfg_ok    = !(width_bad || count_bad || align_bad || bound_bad);
   end

endmodule

// File: rtl/pip_beat_ctrl.sv
module pip_beat_ctrl
   import pip_pkg::*;
#(
   parameter int unsigned CNT_IN_W = 17,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned BND_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                cfg_ok,
   input  logic [CNT_IN_W-1:0] beat_total,
   input  logic [BND_W-1:0]    boundary,
   input  logic [1:0]          width_code,
   output logic                load,
   output logic                advance,
   output logic                row_end,
   output logic [1:0]          width_q,
   output logic                busy,
   output logic                done,
   output logic                err
);

   pip_state_e          state;
   logic [CNT_W-1:0]    remain;
   logic [BND_W-1:0]    row_cnt;
   logic [BND_W-1:0]    bnd_q;
   logic                err_q;
   logic                idle;
   logic                last;
   logic [CNT_IN_W-1:0] tot_m1;

   always_comb begin
      idle    = (state == PIP_IDLE);
      load    = start && idle && cfg_ok;
      advance = (state == PIP_RUN);
      last    = (remain == '0);
      row_end = advance && (row_cnt == bnd_q - 1'b1);
      tot_m1  = beat_total - 1'b1;
      busy    = !idle;
      done    = (state == PIP_DONE);
      err     = err_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PIP_IDLE;
         remain  <= '0;
         row_cnt <= '0;
         bnd_q   <= '0;
         width_q <= 2'd0;
         err_q   <= 1'b0;
      end else begin
         err_q <= start && idle && !cfg_ok;
         case (state)
            PIP_IDLE: begin
               if (load) begin
                  remain  <= tot_m1[CNT_W-1:0];
                  row_cnt <= '0;
                  bnd_q   <= boundary;
                  width_q <= width_code;
                  state   <= PIP_RUN;
               end
            end
            PIP_RUN: begin
               remain  <= remain - 1'b1;
               row_cnt <= row_end ? '0 : row_cnt + 1'b1;
               if (last) state <= PIP_DONE;
            end
            default: state <= PIP_IDLE;
         endcase
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(advance));

   // R4
   row_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && bnd_q != '0) |-> (row_cnt < bnd_q));

   // R8
   err_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy);

   // R9
   width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(width_q));

endmodule

// File: rtl/pip_side_stepper.sv
module pip_side_stepper #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned HOLE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              skip_en,
   input  logic [HOLE_W-1:0] hole,
   input  logic              advance,
   input  logic              row_end,
   input  logic [1:0]        width_q,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] addr_q;
   logic              skip_q;
   logic [HOLE_W-1:0] hole_q;
   logic [HOLE_W-1:0] step_units;
   logic [ADDR_W-1:0] step_bytes;

   always_comb begin
      step_units = (row_end && skip_q) ? hole_q : HOLE_W'(1);
      step_bytes = ADDR_W'(step_units) << width_q;
      addr       = addr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         skip_q <= 1'b0;
         hole_q <= '0;
      end else if (load) begin
         addr_q <= start_addr;
         skip_q <= skip_en;
         hole_q <= hole;
      end else if (advance) begin
         addr_q <= addr_q + step_bytes;
      end
   end

   // R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !load) |=> $stable(addr_q));

   // R3
   unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !row_end) |=> (addr_q == $past(addr_q) + (ADDR_W'(1) << $past(width_q))));

endmodule

// File: rtl/pip_lane_align.sv
module pip_lane_align #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]           rd_data,
   input  logic [$clog2(DATA_W/8)-1:0] src_lane,
   input  logic [$clog2(DATA_W/8)-1:0] dst_lane,
   input  logic [1:0]                  width_q,
   output logic [DATA_W-1:0]           wr_data,
   output logic [DATA_W/8-1:0]         wr_strb
);

   localparam int unsigned NB     = DATA_W / 8;
   localparam int unsigned LANE_W = $clog2(NB);

   logic [3:0] unit_b;

   always_comb unit_b = 4'd1 << width_q;

   for (genvar j = 0; j < NB; j++) begin : g_lane
      localparam logic [LANE_W-1:0] JL = LANE_W'(j);
      logic [LANE_W-1:0] sidx;
      int                off;
      always_comb begin
         sidx = JL - dst_lane + src_lane;
         off  = j - int'(dst_lane);
      end
      assign wr_data[j*8 +: 8] = rd_data[sidx*8 +: 8];
      assign wr_strb[j]        = (off >= 0) && (off < int'(unit_b));
   end

endmodule

// File: rtl/pip_addr_gen.sv
module pip_addr_gen
   import pip_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_IN_W  = 17,
   parameter int unsigned MAX_BEATS = 65535,
   parameter int unsigned BND_W     = 16,
   parameter int unsigned HOLE_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   src_start,
   input  logic [ADDR_W-1:0]   dst_start,
   input  logic [1:0]          width_code,
   input  logic [CNT_IN_W-1:0] beat_total,
   input  logic [BND_W-1:0]    boundary,
   input  logic [HOLE_W-1:0]   src_hole,
   input  logic [HOLE_W-1:0]   dst_hole,
   input  logic                src_skip,
   input  logic                dst_skip,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic                mem_rd_en,
   output logic [ADDR_W-1:0]   mem_rd_addr,
   input  logic [DATA_W-1:0]   mem_rd_data,
   output logic                mem_wr_en,
   output logic [ADDR_W-1:0]   mem_wr_addr,
   output logic [DATA_W-1:0]   mem_wr_data,
   output logic [DATA_W/8-1:0] mem_wr_strb
);

   localparam int unsigned CNT_W      = $clog2(MAX_BEATS + 1);
   localparam int unsigned NB         = DATA_W / 8;
   localparam int unsigned LANE_W     = $clog2(NB);
   localparam int unsigned MAX_W_CODE = LANE_W;

   if (DATA_W != 16 && DATA_W != 32 && DATA_W != 64) begin : g_bad_data
      $error("pip_addr_gen: DATA_W must be 16, 32 or 64");
   end
   if (MAX_BEATS < 1 || CNT_W > CNT_IN_W) begin : g_bad_count
      $error("pip_addr_gen: MAX_BEATS must be at least 1 and fit in CNT_IN_W bits");
   end
   if (ADDR_W < HOLE_W || ADDR_W < 8) begin : g_bad_addr
      $error("pip_addr_gen: ADDR_W must be at least 8 and at least HOLE_W");
   end

   logic              cfg_ok;
   logic              load;
   logic              advance;
   logic              row_end;
   logic [1:0]        width_q;
   logic [ADDR_W-1:0] side_start [PIP_SIDES];
   logic [ADDR_W-1:0] side_addr  [PIP_SIDES];
   logic [HOLE_W-1:0] side_hole  [PIP_SIDES];
   logic [PIP_SIDES-1:0] side_skip;

   always_comb begin
      side_start[PIP_SIDE_SRC] = src_start;
      side_start[PIP_SIDE_DST] = dst_start;
      side_hole[PIP_SIDE_SRC]  = src_hole;
      side_hole[PIP_SIDE_DST]  = dst_hole;
      side_skip[PIP_SIDE_SRC]  = src_skip;
      side_skip[PIP_SIDE_DST]  = dst_skip;
   end

   pip_cfg_check #(
      .ADDR_W     (ADDR_W),
      .CNT_IN_W   (CNT_IN_W),
      .BND_W      (BND_W),
      .MAX_BEATS  (MAX_BEATS),
      .MAX_W_CODE (MAX_W_CODE)
   ) u_cfg (
      .width_code (width_code),
      .src_start  (src_start),
      .dst_start  (dst_start),
      .beat_total (beat_total),
      .boundary   (boundary),
      .src_skip   (src_skip),
      .dst_skip   (dst_skip),
      .cfg_ok     (cfg_ok)
   );

   pip_beat_ctrl #(
      .CNT_IN_W (CNT_IN_W),
      .CNT_W    (CNT_W),
      .BND_W    (BND_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cfg_ok     (cfg_ok),
      .beat_total (beat_total),
      .boundary   (boundary),
      .width_code (width_code),
      .load       (load),
      .advance    (advance),
      .row_end    (row_end),
      .width_q    (width_q),
      .busy       (busy),
      .done       (done),
      .err        (err)
   );

   for (genvar s = 0; s < PIP_SIDES; s++) begin : g_side
      pip_side_stepper #(
         .ADDR_W (ADDR_W),
         .HOLE_W (HOLE_W)
      ) u_step (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (load),
         .start_addr (side_start[s]),
         .skip_en    (side_skip[s]),
         .hole       (side_hole[s]),
         .advance    (advance),
         .row_end    (row_end),
         .width_q    (width_q),
         .addr       (side_addr[s])
      );
   end

   pip_lane_align #(
      .DATA_W (DATA_W)
   ) u_align (
      .rd_data  (mem_rd_data),
      .src_lane (side_addr[PIP_SIDE_SRC][LANE_W-1:0]),
      .dst_lane (side_addr[PIP_SIDE_DST][LANE_W-1:0]),
      .width_q  (width_q),
      .wr_data  (mem_wr_data),
      .wr_strb  (mem_wr_strb)
   );

   always_comb begin
      mem_rd_en   = advance;
      mem_wr_en   = advance;
      mem_rd_addr = side_addr[PIP_SIDE_SRC];
      mem_wr_addr = side_addr[PIP_SIDE_DST];
   end

   // R6
   strb_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($countones(mem_wr_strb) == (1 << width_q)));

   // R2
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (mem_rd_en && mem_rd_addr == $past(src_start) && mem_wr_addr == $past(dst_start)));

endmodule

// File: tb/tb_pip_addr_gen.sv
`timescale 1ns/1ps
module tb_pip_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] src_start = '0;
   logic [31:0] dst_start = '0;
   logic [1:0]  width_code = '0;
   logic [16:0] beat_total = '0;
   logic [15:0] boundary = '0;
   logic [15:0] src_hole = '0;
   logic [15:0] dst_hole = '0;
   logic        src_skip = 1'b0;
   logic        dst_skip = 1'b0;
   logic        busy, done, err;
   logic        mem_rd_en, mem_wr_en;
   logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
   logic [31:0] mem_rd_data;
   logic [3:0]  mem_wr_strb;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pip_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_start(src_start), .dst_start(dst_start), .width_code(width_code),
      .beat_total(beat_total), .boundary(boundary),
      .src_hole(src_hole), .dst_hole(dst_hole),
      .src_skip(src_skip), .dst_skip(dst_skip),
      .busy(busy), .done(done), .err(err),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_strb(mem_wr_strb)
   );

   function automatic logic [7:0] src_byte(input logic [31:0] a);
      logic [31:0] t;
      t = a * 32'd7 + (a >> 8) + 32'h5a;
      return t[7:0];
   endfunction

   // source memory model: word-aligned, answers in the same cycle
   always_comb begin
      logic [31:0] base;
      base = {mem_rd_addr[31:2], 2'b00};
      mem_rd_data = {src_byte(base + 32'd3), src_byte(base + 32'd2),
                     src_byte(base + 32'd1), src_byte(base)};
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000 && !finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
         summary();
         $finish;
      end
   end

   task automatic check_idle(input string tag);
      checks++;
      if (busy || done || err || mem_rd_en || mem_wr_en) begin
         failures++;
         $display("FAIL %s idle: actual busy=%b done=%b err=%b rd=%b wr=%b expected all 0",
                  tag, busy, done, err, mem_rd_en, mem_wr_en);
      end
   endtask

   task automatic check_beat(input string tag, input int i,
                             input logic [31:0] es, input logic [31:0] ed, input int ub);
      logic [31:0] edata, mask;
      logic [3:0]  estrb;
      bit ok;
      edata = '0; mask = '0; estrb = '0;
      for (int k = 0; k < ub; k++) begin
         int lane;
         lane = int'(ed[1:0]) + k;
         edata[lane*8 +: 8] = src_byte(es + 32'(k));
         mask[lane*8 +: 8]  = 8'hff;
         estrb[lane]        = 1'b1;
      end
      ok = mem_rd_en && mem_wr_en && busy && !done && !err &&
           (mem_rd_addr == es) && (mem_wr_addr == ed) &&
           (mem_wr_strb == estrb) && ((mem_wr_data & mask) == edata);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s beat %0d: actual en=%b/%b rd=%h wr=%h strb=%b data=%h expected rd=%h wr=%h strb=%b data=%h",
                  tag, i, mem_rd_en, mem_wr_en, mem_rd_addr, mem_wr_addr, mem_wr_strb,
                  mem_wr_data & mask, es, ed, estrb, edata);
      end
   endtask

   task automatic drive_cfg(input logic [31:0] s, input logic [31:0] d, input logic [1:0] w,
                            input int n, input int bnd, input int sh, input int dh,
                            input bit ss, input bit ds);
      src_start = s; dst_start = d; width_code = w;
      beat_total = 17'(n); boundary = 16'(bnd);
      src_hole = 16'(sh); dst_hole = 16'(dh);
      src_skip = ss; dst_skip = ds;
   endtask

   // behavioural reference: rows counted from the first beat
   task automatic run_xfer(input string tag, input logic [31:0] s, input logic [31:0] d,
                           input logic [1:0] w, input int n, input int bnd,
                           input int sh, input int dh, input bit ss, input bit ds,
                           input bit restart);
      logic [31:0] es, ed;
      int rp;
      bit hit;
      @(negedge clk);
      drive_cfg(s, d, w, n, bnd, sh, dh, ss, ds);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      es = s; ed = d; rp = 0;
      for (int i = 0; i < n; i++) begin
         check_beat(tag, i, es, ed, 1 << w);
         if (restart && i == 1) begin
            // R9: restart with other settings while running
            drive_cfg(32'h9000, 32'hA000, 2'd0, 3, 1, 7, 7, 1'b1, 1'b1);
            start = 1'b1;
         end
         if (restart && i == 2) start = 1'b0;
         hit = (rp == bnd - 1);
         rp  = hit ? 0 : rp + 1;
         es  = es + 32'(((hit && ss) ? sh : 1) << w);
         ed  = ed + 32'(((hit && ds) ? dh : 1) << w);
         @(negedge clk);
      end
      checks++;
      if (!(done && busy && !mem_rd_en && !mem_wr_en)) begin
         failures++;
         $display("FAIL R7 %s end: actual done=%b busy=%b rd=%b wr=%b expected 1 1 0 0",
                  tag, done, busy, mem_rd_en, mem_wr_en);
      end
      @(negedge clk);
      check_idle({"R7 ", tag});
   endtask

   task automatic err_case(input string tag, input logic [31:0] s, input logic [31:0] d,
                           input logic [1:0] w, input int n, input int bnd,
                           input bit ss, input bit ds);
      @(negedge clk);
      drive_cfg(s, d, w, n, bnd, 3, 3, ss, ds);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      checks++;
      if (!(err && !busy && !mem_rd_en && !done)) begin
         failures++;
         $display("FAIL %s reject: actual err=%b busy=%b rd=%b done=%b expected 1 0 0 0",
                  tag, err, busy, mem_rd_en, done);
      end
      @(negedge clk);
      check_idle({tag, " after reject"});
   endtask

   initial begin
      // R1: reset state
      #1;
      check_idle("R1 in reset");
      repeat (3) @(negedge clk);
      check_idle("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after reset");

      // R2 R3: skip off both sides, hole programmed but ignored
      run_xfer("R3", 32'h0000_1000, 32'h0000_8000, 2'd2, 12, 4, 40, 50, 1'b0, 1'b0, 1'b0);
      // R2 R4: both sides skip, different holes
      run_xfer("R4", 32'h0000_2000, 32'h0000_9000, 2'd2, 12, 4, 3, 6, 1'b1, 1'b1, 1'b0);
      // R5: source skip only, destination hole ignored
      run_xfer("R5", 32'h0000_0102, 32'h0000_2006, 2'd1, 10, 3, 4, 9, 1'b1, 1'b0, 1'b0);
      // R5 R6: destination skip only, byte units, lanes differ, partial last row
      run_xfer("R6", 32'h0000_0301, 32'h0000_4003, 2'd0, 17, 5, 2, 11, 1'b0, 1'b1, 1'b0);
      // R6: halfword, source upper lane to destination lower lane
      run_xfer("R6", 32'h0000_0502, 32'h0000_6000, 2'd1, 6, 2, 3, 5, 1'b1, 1'b1, 1'b0);
      // R4: row length one
      run_xfer("R4", 32'h0000_0700, 32'h0000_7002, 2'd1, 5, 1, 2, 3, 1'b1, 1'b1, 1'b0);
      // R9: start while busy ignored
      run_xfer("R9", 32'h0000_3000, 32'h0000_B000, 2'd2, 8, 2, 5, 3, 1'b1, 1'b1, 1'b1);
      // R2: single beat
      run_xfer("R2", 32'h0000_0044, 32'h0000_0088, 2'd2, 1, 1, 9, 9, 1'b1, 1'b1, 1'b0);

      // R8: rejection causes
      err_case("R8 count zero", 32'h100, 32'h200, 2'd2, 0, 4, 1'b0, 1'b0);
      err_case("R8 width code 3", 32'h100, 32'h200, 2'd3, 4, 4, 1'b0, 1'b0);
      err_case("R8 src misaligned", 32'h102, 32'h200, 2'd2, 4, 4, 1'b0, 1'b0);
      err_case("R8 dst misaligned", 32'h100, 32'h201, 2'd1, 4, 4, 1'b0, 1'b0);
      err_case("R8 boundary zero skip", 32'h100, 32'h200, 2'd0, 4, 0, 1'b1, 1'b0);
      // R8: boundary zero accepted with skips off
      run_xfer("R8", 32'h0000_0800, 32'h0000_0900, 2'd0, 5, 0, 4, 4, 1'b0, 1'b0, 1'b0);
      // R10: count limits
      err_case("R10 count 65536", 32'h100, 32'h200, 2'd0, 65536, 4, 1'b0, 1'b0);
      run_xfer("R10", 32'h0001_0000, 32'h0010_0001, 2'd0, 65535, 255, 2, 3, 1'b1, 1'b1, 1'b0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule